// File: doc/BRIEF.md
# NAND Flash Device Command Interface

This block is the device-side front end of a small NAND-style flash memory. Its strobe inputs are asynchronous: chip enable, command latch, address latch, write enable, read enable and write protect, plus an 8-bit I/O bus. A fast system clock samples them through two-stage synchronisers, and edge detectors turn them into single-cycle events. Each rising write-enable edge delivers one byte. Command latch high makes it a command, address latch high makes it a column address, and with neither high it is a data byte. A column counter selects the byte of a page-wide data register. The counter advances on every falling read-enable edge. The flash array is a single behavioural page register.

Read, program and erase operations each run for a parameterised number of clock cycles. For that time the block drives an open-drain pull-down enable that signals busy. When chip enable goes high during a program or erase, the operation continues. During a read the same event aborts the operation, unless the chip-enable don't-care option is set. Write protect blocks program and erase at their confirm command. For a parameterised number of cycles after reset the block accepts no strobe.

Top module: `nfc_dev_front`

## Requirements
- R1: For POR_CYCLES clock cycles after reset release, every write-enable strobe is ignored, so no operation can start in that window.
- R2: A byte is captured on a rising write-enable edge while chip enable (ce_n) is low. It is a command if cle is high, a column address (low COL_W bits) if ale is high, and a data byte if neither is high. Data bytes are stored only after the program setup command 0x80.
- R3: Each falling read-enable edge, with ce_n low and the block ready, presents the data-register byte at the current column on io_out. It then advances the column by one, wrapping at 2**COL_W.
- R4: The sequence command 0x00, an address byte, then command 0x30 holds busy for exactly T_READ cycles. At the end the array page is copied into the data register.
- R5: The sequence command 0x80, an address byte, data bytes at consecutive columns, then command 0x10 holds busy for exactly T_PROG cycles. At the end the data register is copied into the array page.
- R6: Command 0x60 followed by 0xD0 holds busy for exactly T_ERASE cycles. At the end every array byte is 0xFF.
- R7: ce_n going high during a program or erase busy period has no effect. The busy length and the result are unchanged.
- R8: With CE_DONT_CARE=0, ce_n going high during a read busy period ends busy early, and the data register keeps its previous contents.
- R9: With CE_DONT_CARE=1, ce_n going high during a read busy period does not interrupt the read.
- R10: With wp_n low at the confirm command (0x10 or 0xD0), no busy period starts and the array is unchanged.
- R11: rb_pull is 1 exactly while an operation is in progress and 0 from reset. Write-enable strobes during busy are ignored.
- R12: io_oe is 1 only while ce_n is low, re_n is low and the block is ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| cle | input | 1 | Command latch enable |
| ale | input | 1 | Address latch enable |
| we_n | input | 1 | Write enable strobe, active low |
| re_n | input | 1 | Read enable strobe, active low |
| wp_n | input | 1 | Write protect, active low |
| io_in | input | 8 | I/O bus input byte |
| io_out | output | 8 | I/O bus output byte |
| io_oe | output | 1 | Output enable for the I/O bus |
| rb_pull | output | 1 | Open-drain pull-down enable; 1 means busy |

## Verification
A wrong busy counter shows at once as a pull-down interval that is longer or shorter than its parameter, and the bench measures that interval to the cycle. A mis-routed byte or a wrong column counter shows on the next read strobe as a byte from the wrong column. A missed load or commit, or a wrong abort decision, shows only on the next page read, a few strobes later. It is exposed by reading back patterns that differ between the array and the data register.

// File: rtl/nfc_pkg.sv
package nfc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_ADDR,
        ST_PG_DATA,
        ST_ER_WAIT,
        ST_BUSY_RD,
        ST_BUSY_PG,
        ST_BUSY_ER
    } nfc_state_e;

    localparam logic [7:0] NFC_CMD_RD_SETUP = 8'h00;
    localparam logic [7:0] NFC_CMD_RD_GO    = 8'h30;
    localparam logic [7:0] NFC_CMD_PG_SETUP = 8'h80;
    localparam logic [7:0] NFC_CMD_PG_GO    = 8'h10;
    localparam logic [7:0] NFC_CMD_ER_SETUP = 8'h60;
    localparam logic [7:0] NFC_CMD_ER_GO    = 8'hD0;
endpackage

// File: rtl/nfc_strobe_sync.sv
module nfc_strobe_sync #(
    parameter int             W       = 14,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw,
    output logic [W-1:0] sync
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic stage1_q;
        logic stage2_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage1_q <= RST_VAL[i];
                stage2_q <= RST_VAL[i];
            end else begin
                stage1_q <= raw[i];
                stage2_q <= stage1_q;
            end
        end
        assign sync[i] = stage2_q;
    end
endmodule

// File: rtl/nfc_page_store.sv
module nfc_page_store #(
    parameter int COL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [COL_W-1:0] wr_col,
    input  logic [7:0]       wr_byte,
    input  logic [COL_W-1:0] rd_col,
    output logic [7:0]       rd_byte,
    input  logic             load_page,
    input  logic             commit_page,
    input  logic             erase_page
);
    localparam int PAGE_BYTES = 1 << COL_W;

    logic [7:0] cells_q [PAGE_BYTES];
    logic [7:0] dreg_q  [PAGE_BYTES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < PAGE_BYTES; i++) begin
                cells_q[i] <= 8'hFF;
                dreg_q[i]  <= 8'hFF;
            end
        end else begin
            if (load_page) begin
                for (int i = 0; i < PAGE_BYTES; i++) dreg_q[i] <= cells_q[i];
            end else if (wr_en) begin
                dreg_q[wr_col] <= wr_byte;
            end
            if (commit_page) begin
                for (int i = 0; i < PAGE_BYTES; i++) cells_q[i] <= dreg_q[i];
            end else if (erase_page) begin
                for (int i = 0; i < PAGE_BYTES; i++) cells_q[i] <= 8'hFF;
            end
        end
    end

    assign rd_byte = dreg_q[rd_col];
endmodule

// File: rtl/nfc_dev_front.sv
module nfc_dev_front
    import nfc_pkg::*;
#(
    parameter int COL_W        = 4,
    parameter int T_READ       = 12,
    parameter int T_PROG       = 40,
    parameter int T_ERASE      = 60,
    parameter int POR_CYCLES   = 200,
    parameter bit CE_DONT_CARE = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ce_n,
    input  logic       cle,
    input  logic       ale,
    input  logic       we_n,
    input  logic       re_n,
    input  logic       wp_n,
    input  logic [7:0] io_in,
    output logic [7:0] io_out,
    output logic       io_oe,
    output logic       rb_pull
);
    localparam int T_MAX = (T_READ > T_PROG) ? ((T_READ > T_ERASE) ? T_READ : T_ERASE)
                                             : ((T_PROG > T_ERASE) ? T_PROG : T_ERASE);
    localparam int CNT_W = $clog2(T_MAX + 1);
    localparam int POR_W = $clog2(POR_CYCLES + 1);
    localparam int SYN_W = 14;
    localparam logic [SYN_W-1:0] SYN_RST = 14'h0019;

    typedef struct packed {
        nfc_state_e       st;
        logic [CNT_W-1:0] cnt;
        logic [COL_W-1:0] col;
        logic [7:0]       dout;
        logic [POR_W-1:0] por;
        logic             we_prev;
        logic             re_prev;
    } regs_t;

    regs_t r_d, r_q;

    logic [SYN_W-1:0] syn;
    logic             ce_n_s, cle_s, ale_s, we_n_s, re_n_s, wp_n_s;
    logic [7:0]       io_s;
    logic             we_rise, re_fall, por_done, busy, pg_er_busy, strobe_ok;
    logic             buf_we, load_pg, commit_pg, erase_pg;
    logic [7:0]       rd_byte;
    logic [COL_W-1:0] col_q;
    logic [CNT_W-1:0] busy_cnt;

    nfc_strobe_sync #(.W(SYN_W), .RST_VAL(SYN_RST)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .raw  ({io_in, wp_n, re_n, we_n, ale, cle, ce_n}),
        .sync (syn)
    );

    assign {io_s, wp_n_s, re_n_s, we_n_s, ale_s, cle_s, ce_n_s} = syn;

    nfc_page_store #(.COL_W(COL_W)) u_page (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (buf_we),
        .wr_col     (r_q.col),
        .wr_byte    (io_s),
        .rd_col     (r_q.col),
        .rd_byte    (rd_byte),
        .load_page  (load_pg),
        .commit_page(commit_pg),
        .erase_page (erase_pg)
    );

    assign we_rise    = we_n_s && !r_q.we_prev;
    assign re_fall    = !re_n_s && r_q.re_prev;
    assign por_done   = (r_q.por == POR_W'(POR_CYCLES));
    assign busy       = (r_q.st == ST_BUSY_RD) || (r_q.st == ST_BUSY_PG) || (r_q.st == ST_BUSY_ER);
    assign pg_er_busy = (r_q.st == ST_BUSY_PG) || (r_q.st == ST_BUSY_ER);
    assign strobe_ok  = we_rise && !ce_n_s && por_done && !busy;
    assign col_q      = r_q.col;
    assign busy_cnt   = r_q.cnt;

    always_comb begin
        r_d         = r_q;
        r_d.we_prev = we_n_s;
        r_d.re_prev = re_n_s;
        buf_we      = 1'b0;
        load_pg     = 1'b0;
        commit_pg   = 1'b0;
        erase_pg    = 1'b0;
        if (!por_done) r_d.por = r_q.por + 1'b1;

        case (r_q.st)
            ST_BUSY_RD: begin
                if (!CE_DONT_CARE && ce_n_s) begin
                    r_d.st = ST_IDLE;
                end else if (r_q.cnt == '0) begin
                    r_d.st  = ST_IDLE;
                    load_pg = 1'b1;
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            ST_BUSY_PG: begin
                if (r_q.cnt == '0) begin
                    r_d.st    = ST_IDLE;
                    commit_pg = 1'b1;
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            ST_BUSY_ER: begin
                if (r_q.cnt == '0) begin
                    r_d.st   = ST_IDLE;
                    erase_pg = 1'b1;
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            default: begin
                if (strobe_ok) begin
                    if (cle_s) begin
                        case (io_s)
                            NFC_CMD_RD_SETUP: r_d.st = ST_RD_ADDR;
                            NFC_CMD_PG_SETUP: r_d.st = ST_PG_DATA;
                            NFC_CMD_ER_SETUP: r_d.st = ST_ER_WAIT;
                            NFC_CMD_RD_GO: begin
                                if (r_q.st == ST_RD_ADDR) begin
                                    r_d.st  = ST_BUSY_RD;
                                    r_d.cnt = CNT_W'(T_READ - 1);
                                end else begin
                                    r_d.st = ST_IDLE;
                                end
                            end
                            NFC_CMD_PG_GO: begin
                                if (r_q.st == ST_PG_DATA && wp_n_s) begin
                                    r_d.st  = ST_BUSY_PG;
                                    r_d.cnt = CNT_W'(T_PROG - 1);
                                end else begin
                                    r_d.st = ST_IDLE;
                                end
                            end
                            NFC_CMD_ER_GO: begin
                                if (r_q.st == ST_ER_WAIT && wp_n_s) begin
                                    r_d.st  = ST_BUSY_ER;
                                    r_d.cnt = CNT_W'(T_ERASE - 1);
                                end else begin
                                    r_d.st = ST_IDLE;
                                end
                            end
                            default: r_d.st = ST_IDLE;
                        endcase
                    end else if (ale_s) begin
                        r_d.col = io_s[COL_W-1:0];
                    end else if (r_q.st == ST_PG_DATA) begin
                        buf_we  = 1'b1;
                        r_d.col = r_q.col + 1'b1;
                    end
                end
                if (re_fall && !ce_n_s) begin
                    r_d.dout = rd_byte;
                    r_d.col  = r_q.col + 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st      <= ST_IDLE;
            r_q.cnt     <= '0;
            r_q.col     <= '0;
            r_q.dout    <= '0;
            r_q.por     <= '0;
            r_q.we_prev <= 1'b1;
            r_q.re_prev <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign io_out  = r_q.dout;
    assign io_oe   = !ce_n_s && !re_n_s && !busy;
    assign rb_pull = busy;
endmodule

// File: rtl/nfc_dev_front_chk.sv
module nfc_dev_front_chk #(
    parameter int COL_W = 4,
    parameter int CNT_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rb_pull,
    input logic             io_oe,
    input logic             por_done,
    input logic             we_rise,
    input logic             re_fall,
    input logic             ce_n_s,
    input logic             pg_er_busy,
    input logic [CNT_W-1:0] busy_cnt,
    input logic [COL_W-1:0] col_q
);
    assert_lockout_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !por_done |=> !rb_pull);

    assert_col_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (re_fall && !ce_n_s && !rb_pull) |=> (col_q == COL_W'($past(col_q) + 1'b1)));

    assert_ce_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pg_er_busy && busy_cnt != '0) |=> rb_pull);

    assert_busy_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rb_pull) |-> $past(we_rise));

    assert_oe_ready_R12: assert property (@(posedge clk) disable iff (!rst_n)
        io_oe |-> !rb_pull);
endmodule

bind nfc_dev_front nfc_dev_front_chk #(.COL_W(COL_W), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rb_pull   (rb_pull),
    .io_oe     (io_oe),
    .por_done  (por_done),
    .we_rise   (we_rise),
    .re_fall   (re_fall),
    .ce_n_s    (ce_n_s),
    .pg_er_busy(pg_er_busy),
    .busy_cnt  (busy_cnt),
    .col_q     (col_q)
);

// File: tb/nfc_dev_front_tb.sv
`timescale 1ns/1ps
module nfc_dev_front_tb;
    localparam int COL_W = 4;
    localparam int PB    = 1 << COL_W;
    localparam int T_RD  = 12;
    localparam int T_PG  = 40;
    localparam int T_ER  = 60;
    localparam int POR   = 200;
    localparam int WIN   = T_ER + 30;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce_n = 1'b1, cle = 1'b0, ale = 1'b0, we_n = 1'b1, re_n = 1'b1, wp_n = 1'b1;
    logic [7:0] io_in = 8'h00;
    logic [7:0] out0, out1;
    logic oe0, oe1, rb0, rb1;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    logic [7:0] m_buf [PB];
    logic [7:0] m_arr [PB];

    always #2.5 clk = ~clk;

    nfc_dev_front #(.COL_W(COL_W), .T_READ(T_RD), .T_PROG(T_PG), .T_ERASE(T_ER),
                    .POR_CYCLES(POR), .CE_DONT_CARE(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cle(cle), .ale(ale), .we_n(we_n),
        .re_n(re_n), .wp_n(wp_n), .io_in(io_in), .io_out(out0), .io_oe(oe0), .rb_pull(rb0));

    nfc_dev_front #(.COL_W(COL_W), .T_READ(T_RD), .T_PROG(T_PG), .T_ERASE(T_ER),
                    .POR_CYCLES(POR), .CE_DONT_CARE(1'b1)) u_dut_dc (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cle(cle), .ale(ale), .we_n(we_n),
        .re_n(re_n), .wp_n(wp_n), .io_in(io_in), .io_out(out1), .io_oe(oe1), .rb_pull(rb1));

    function automatic logic [7:0] exp_byte(input int c);
        return m_buf[c % PB];
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_byte(input logic c, input logic a, input logic [7:0] b);
        cle = c; ale = a; io_in = b;
        @(negedge clk);
        we_n = 1'b0;
        repeat (3) @(negedge clk);
        we_n = 1'b1;
        repeat (4) @(negedge clk);
        cle = 1'b0; ale = 1'b0;
    endtask

    task automatic confirm(input logic [7:0] cmd, input int ce_at, output int c0, output int c1);
        cle = 1'b1; io_in = cmd;
        @(negedge clk);
        we_n = 1'b0;
        repeat (3) @(negedge clk);
        we_n = 1'b1;
        c0 = 0; c1 = 0;
        for (int i = 0; i < WIN; i++) begin
            @(negedge clk);
            if (i == ce_at) ce_n = 1'b1;
            c0 += int'(rb0);
            c1 += int'(rb1);
        end
        cle = 1'b0; ce_n = 1'b0;
        @(negedge clk);
    endtask

    task automatic rd_byte(output logic [7:0] b0, output logic [7:0] b1, output logic oe);
        re_n = 1'b0;
        repeat (5) @(negedge clk);
        b0 = out0; b1 = out1; oe = oe0;
        re_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic program_page(input int col, input int len, input int ce_at,
                                output int c0, output int c1);
        wr_byte(1'b1, 1'b0, 8'h80);
        wr_byte(1'b0, 1'b1, 8'(col));
        for (int k = 0; k < len; k++) begin
            logic [7:0] d;
            d = 8'($urandom);
            wr_byte(1'b0, 1'b0, d);
            m_buf[(col + k) % PB] = d;
        end
        confirm(8'h10, ce_at, c0, c1);
        if (wp_n) for (int k = 0; k < PB; k++) m_arr[k] = m_buf[k];
    endtask

    task automatic read_page(input int col, input int ce_at, output int c0, output int c1);
        wr_byte(1'b1, 1'b0, 8'h00);
        wr_byte(1'b0, 1'b1, 8'(col));
        confirm(8'h30, ce_at, c0, c1);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int c0, c1;
        logic [7:0] b0, b1;
        logic oe;
        void'($urandom(32'd20240611));
        for (int k = 0; k < PB; k++) begin m_buf[k] = 8'hFF; m_arr[k] = 8'hFF; end

        repeat (5) @(negedge clk);
        chk("R11 reset rb_pull", 32'(rb0), 32'd0);
        chk("R12 reset io_oe", 32'(oe0), 32'd0);
        rst_n = 1'b1;
        ce_n = 1'b0;

        // R1: erase attempt inside the lockout window
        wr_byte(1'b1, 1'b0, 8'h60);
        confirm(8'hD0, -1, c0, c1);
        chk("R1 lockout busy cycles", 32'(c0), 32'd0);
        repeat (POR) @(negedge clk);

        // R5 directed program of full page, R7 ce high during program
        program_page(0, PB, 8, c0, c1);
        chk("R5 R7 program busy cycles", 32'(c0), 32'(T_PG));
        chk("R7 program busy cycles dc", 32'(c1), 32'(T_PG));

        // R4 read back, R2 address routing, R3 column walk and wrap
        read_page(0, -1, c0, c1);
        chk("R4 read busy cycles", 32'(c0), 32'(T_RD));
        for (int k = 0; k < PB; k++) m_buf[k] = m_arr[k];
        for (int k = 0; k <= PB; k++) begin
            rd_byte(b0, b1, oe);
            chk($sformatf("R3 column %0d", k), 32'(b0), 32'(exp_byte(k)));
        end
        chk("R12 io_oe during read strobe", 32'(oe), 32'd1);
        read_page(5, -1, c0, c1);
        rd_byte(b0, b1, oe);
        chk("R2 address byte sets column", 32'(b0), 32'(exp_byte(5)));

        // R12 chip deselected
        ce_n = 1'b1; re_n = 1'b0;
        repeat (5) @(negedge clk);
        chk("R12 io_oe with ce_n high", 32'(oe0), 32'd0);
        re_n = 1'b1; ce_n = 1'b0;
        repeat (3) @(negedge clk);

        // R6 erase with R7 ce high during busy
        wr_byte(1'b1, 1'b0, 8'h60);
        confirm(8'hD0, 10, c0, c1);
        chk("R6 R7 erase busy cycles", 32'(c0), 32'(T_ER));
        for (int k = 0; k < PB; k++) m_arr[k] = 8'hFF;

        // R8 / R9 read with ce high during busy
        read_page(0, 3, c0, c1);
        chk("R8 aborted read ends early", 32'((c0 > 0) && (c0 < T_RD)), 32'd1);
        chk("R9 read completes with dont-care", 32'(c1), 32'(T_RD));
        rd_byte(b0, b1, oe);
        chk("R8 data register kept", 32'(b0), 32'(exp_byte(0)));
        chk("R9 data register loaded", 32'(b1), 32'hFF);

        // R10 write protect
        wp_n = 1'b0;
        repeat (4) @(negedge clk);
        program_page(0, 3, -1, c0, c1);
        chk("R10 program rejected", 32'(c0), 32'd0);
        wr_byte(1'b1, 1'b0, 8'h60);
        confirm(8'hD0, -1, c0, c1);
        chk("R10 erase rejected", 32'(c0), 32'd0);
        wp_n = 1'b1;
        repeat (4) @(negedge clk);
        read_page(0, -1, c0, c1);
        for (int k = 0; k < PB; k++) m_buf[k] = m_arr[k];
        for (int k = 0; k < 3; k++) begin
            rd_byte(b0, b1, oe);
            chk($sformatf("R10 array unchanged col %0d", k), 32'(b0), 32'(exp_byte(k)));
        end

        // R11 strobes ignored while busy
        wr_byte(1'b1, 1'b0, 8'h60);
        cle = 1'b1; io_in = 8'hD0;
        @(negedge clk); we_n = 1'b0;
        repeat (3) @(negedge clk); we_n = 1'b1;
        repeat (3) @(negedge clk); cle = 1'b0;
        wr_byte(1'b1, 1'b0, 8'h80);
        chk("R11 busy during erase", 32'(rb0), 32'd1);
        repeat (WIN) @(negedge clk);
        confirm(8'h10, -1, c0, c1);
        chk("R11 setup during busy ignored", 32'(c0), 32'd0);

        // random program / read rounds
        for (int it = 0; it < 6; it++) begin
            int col, len, rc, rl;
            col = int'($urandom % PB);
            len = 1 + int'($urandom % PB);
            program_page(col, len, -1, c0, c1);
            chk("R5 random program busy", 32'(c0), 32'(T_PG));
            rc = int'($urandom % PB);
            rl = 1 + int'($urandom % PB);
            read_page(rc, -1, c0, c1);
            for (int k = 0; k < PB; k++) m_buf[k] = m_arr[k];
            for (int k = 0; k < rl; k++) begin
                rd_byte(b0, b1, oe);
                chk("R3 R5 random read byte", 32'(b0), 32'(exp_byte(rc + k)));
            end
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule